// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers five controller status conditions into one readable 8-bit status word and drives a single registered interrupt line. Two of the conditions are levels that the controller raises and retires itself: transmitter available and receiver inhibited. The other three are sticky flags set by one-cycle event pulses: reconfiguration, excessive NAK and new peer ID. Each sticky flag has its own way of being cleared: a clear-flags command, a power-on-clear command, or a host read of the peer-ID register.

A host-written 8-bit mask register holds one enable bit per condition, in the same bit position as that condition's status bit. The interrupt line is the registered OR of every status bit ANDed with its mask bit. Masking a level condition only hides it: the line asserts again when the mask bit is set again while the condition still holds. The bit layout is: bit 0 transmitter available, bit 1 new peer ID, bit 2 reconfiguration, bit 3 excessive NAK, bit 7 receiver inhibited. Bits 4 to 6 carry no source.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the mask reads 0x00, all sticky flags read 0 and irq_o is low.
- R2: A mask write stores wdata in bits 0, 1, 2, 3 and 7 from the next cycle on; bits 4, 5 and 6 ignore the write and always read 0.
- R3: irq_o equals, one clock after the inputs settle, the OR over bits 0 to 3 and 7 of status_o AND mask_o; it deasserts one clock after the last enabled source is cleared or masked.
- R4: status_o bit 0 follows tx_avail_i and bit 7 follows rx_inhib_i in the same cycle; masking either only hides it, and re-enabling the mask reasserts irq_o if the level is still high.
- R5: A reconf_evt_i pulse sets status bit 2 the next cycle; it stays set until a clr_flags_i pulse, which clears it the next cycle.
- R6: A nak_evt_i pulse sets status bit 3; only por_clr_i clears it, and clr_flags_i or peer_rd_i leave it set.
- R7: A peer_evt_i pulse sets status bit 1; only peer_rd_i clears it, and clr_flags_i or por_clr_i leave it set.
- R8: When a sticky flag's set pulse and its clear strobe arrive in the same cycle, the flag is set.
- R9: Status bits 4, 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_avail_i | input | 1 | Transmitter-available level |
| rx_inhib_i | input | 1 | Receiver-inhibited level |
| reconf_evt_i | input | 1 | Reconfiguration event pulse |
| nak_evt_i | input | 1 | Excessive-NAK event pulse |
| peer_evt_i | input | 1 | New-peer-ID event pulse |
| clr_flags_i | input | 1 | Clear-flags command strobe |
| por_clr_i | input | 1 | Power-on-clear command strobe |
| peer_rd_i | input | 1 | Host read of the peer-ID register |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 8 | Mask write data |
| mask_o | output | 8 | Current mask |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Sticky flags and mask writes land at the edge that samples the pulse, so status_o and mask_o are due one cycle later, level bits appear in status_o in the same cycle, and irq_o trails status_o and mask_o by exactly one further edge. The bench drives every input on the falling edge and samples on the falling edge, reading status and mask one edge after a stimulus and irq_o two edges after. A sweep of all 256 mask values against all 32 source patterns computes the expected line arithmetically, and directed sequences cover the per-flag clear rules and set-over-clear collisions.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int STW       = 8;
  localparam int POS_TX    = 0;
  localparam int POS_PEER  = 1;
  localparam int POS_RECF  = 2;
  localparam int POS_NAK   = 3;
  localparam int POS_RXI   = 7;
  localparam int NSTICKY   = 3;
  localparam int IDX_RECF  = 0;
  localparam int IDX_NAK   = 1;
  localparam int IDX_PEER  = 2;

  localparam logic [STW-1:0] SRC_BITS =
    STW'((1 << POS_TX) | (1 << POS_PEER) | (1 << POS_RECF) |
         (1 << POS_NAK) | (1 << POS_RXI));

  function automatic logic [STW-1:0] keep_src(input logic [STW-1:0] v);
    return v & SRC_BITS;
  endfunction

  function automatic logic any_enabled(input logic [STW-1:0] st,
                                       input logic [STW-1:0] mk);
    return |(st & mk & SRC_BITS);
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_agg_pkg::*;
#(
  parameter int W = STW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] wr_val;
  assign wr_val = W'(keep_src(STW'(wdata)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= wr_val;
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mask_q == W'(keep_src(STW'($past(wdata)))));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask_q));
endmodule

// File: rtl/irq_sticky_flags.sv
module irq_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_p,
  input  logic [N-1:0] clr_p,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_p[i]) flag_q[i] <= 1'b1;
      else if (clr_p[i]) flag_q[i] <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_p[i] |=> flag_q[i]);
    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_p[i] && !set_p[i]) |=> !flag_q[i]);
    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_p[i] && !set_p[i]) |=> $stable(flag_q[i]));
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_agg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] status,
  input  logic [STW-1:0] mask,
  output logic           irq_q
);
  logic pending;
  assign pending = any_enabled(status, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending;
  end

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> irq_q);
  // R3
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq_q);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_avail_i,
  input  logic           rx_inhib_i,
  input  logic           reconf_evt_i,
  input  logic           nak_evt_i,
  input  logic           peer_evt_i,
  input  logic           clr_flags_i,
  input  logic           por_clr_i,
  input  logic           peer_rd_i,
  input  logic           mask_we_i,
  input  logic [STW-1:0] mask_wdata_i,
  output logic [STW-1:0] mask_o,
  output logic [STW-1:0] status_o,
  output logic           irq_o
);
  logic [NSTICKY-1:0] ev_set, ev_clr, flags;

  always_comb begin
    ev_set = '0;
    ev_clr = '0;
    ev_set[IDX_RECF] = reconf_evt_i;
    ev_set[IDX_NAK]  = nak_evt_i;
    ev_set[IDX_PEER] = peer_evt_i;
    ev_clr[IDX_RECF] = clr_flags_i;
    ev_clr[IDX_NAK]  = por_clr_i;
    ev_clr[IDX_PEER] = peer_rd_i;
  end

  irq_sticky_flags #(.N(NSTICKY)) i_flags (
    .clk(clk), .rst_n(rst_n), .set_p(ev_set), .clr_p(ev_clr), .flag_q(flags)
  );

  irq_mask_reg #(.W(STW)) i_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we_i), .wdata(mask_wdata_i),
    .mask_q(mask_o)
  );

  always_comb begin
    status_o           = '0;
    status_o[POS_TX]   = tx_avail_i;
    status_o[POS_RXI]  = rx_inhib_i;
    status_o[POS_RECF] = flags[IDX_RECF];
    status_o[POS_NAK]  = flags[IDX_NAK];
    status_o[POS_PEER] = flags[IDX_PEER];
  end

  irq_combiner i_comb (
    .clk(clk), .rst_n(rst_n), .status(status_o), .mask(mask_o), .irq_q(irq_o)
  );

  // R9
  status_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~SRC_BITS) == '0);
  // R2
  mask_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~SRC_BITS) == '0);
endmodule

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_avail_i = 0, rx_inhib_i = 0, reconf_evt_i = 0, nak_evt_i = 0;
  logic peer_evt_i = 0, clr_flags_i = 0, por_clr_i = 0, peer_rd_i = 0;
  logic mask_we_i = 0;
  logic [7:0] mask_wdata_i = 8'h00;
  logic [7:0] mask_o, status_o;
  logic irq_o;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg i_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .tx_avail_i(tx_avail_i), .rx_inhib_i(rx_inhib_i),
    .reconf_evt_i(reconf_evt_i), .nak_evt_i(nak_evt_i), .peer_evt_i(peer_evt_i),
    .clr_flags_i(clr_flags_i), .por_clr_i(por_clr_i), .peer_rd_i(peer_rd_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .mask_o(mask_o),
    .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic nstep();
    @(negedge clk);
  endtask

  task automatic quiet();
    reconf_evt_i = 0; nak_evt_i = 0; peer_evt_i = 0;
    clr_flags_i = 0; por_clr_i = 0; peer_rd_i = 0; mask_we_i = 0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_we_i = 1; mask_wdata_i = m; nstep(); mask_we_i = 0;
  endtask

  // pattern bits: 0 tx, 1 peer, 2 reconf, 3 nak, 4 rx_inhib
  function automatic logic [7:0] pat_to_status(input logic [4:0] p);
    return {p[4], 3'b000, p[3], p[2], p[1], p[0]};
  endfunction

  initial begin
    nstep(); nstep();
    // R1 reset state
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 status", status_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    rst_n = 1; nstep();

    // R2 R3 R4 R9 sweep: every mask against every source pattern
    for (int m = 0; m < 256; m++) begin
      write_mask(8'(m));
      chk("R2 mask readback", mask_o, 8'(m) & 8'h8F);
      for (int p = 0; p < 32; p++) begin
        logic [7:0] es;
        logic [4:0] pb;
        pb = 5'(p);
        clr_flags_i = 1; por_clr_i = 1; peer_rd_i = 1; nstep();
        quiet();
        peer_evt_i = pb[1]; reconf_evt_i = pb[2]; nak_evt_i = pb[3];
        tx_avail_i = pb[0]; rx_inhib_i = pb[4];
        nstep();
        quiet();
        es = pat_to_status(pb);
        chk("R4 R9 status", status_o, es);
        nstep();
        chk("R3 irq", {7'b0, irq_o}, {7'b0, |(es & 8'(m) & 8'h8F)});
      end
    end
    tx_avail_i = 0; rx_inhib_i = 0;
    clr_flags_i = 1; por_clr_i = 1; peer_rd_i = 1; nstep(); quiet(); nstep();
    chk("R3 all cleared irq", {7'b0, irq_o}, 8'h00);

    // R4 hide and reveal receiver-inhibited
    write_mask(8'h80); rx_inhib_i = 1; nstep(); nstep();
    chk("R4 rx irq on", {7'b0, irq_o}, 8'h01);
    write_mask(8'h00); nstep();
    chk("R4 rx masked", {7'b0, irq_o}, 8'h00);
    chk("R4 rx still in status", status_o, 8'h80);
    write_mask(8'h80); nstep();
    chk("R4 rx reappears", {7'b0, irq_o}, 8'h01);
    rx_inhib_i = 0; nstep(); nstep();
    chk("R3 level gone", {7'b0, irq_o}, 8'h00);

    // R5 R6 R7 clear routing
    write_mask(8'h0E);
    reconf_evt_i = 1; nak_evt_i = 1; peer_evt_i = 1; nstep(); quiet();
    chk("R5 R6 R7 set", status_o, 8'h0E);
    clr_flags_i = 1; nstep(); quiet();
    chk("R5 clr_flags clears only reconf", status_o, 8'h0A);
    por_clr_i = 1; nstep(); quiet();
    chk("R6 por_clr clears nak only", status_o, 8'h02);
    chk("R3 irq still peer", {7'b0, irq_o}, 8'h01);
    peer_rd_i = 1; nstep(); quiet();
    chk("R7 peer_rd clears peer", status_o, 8'h00);
    nstep();
    chk("R3 irq drops", {7'b0, irq_o}, 8'h00);
    nak_evt_i = 1; peer_evt_i = 1; nstep(); quiet();
    clr_flags_i = 1; nstep(); quiet();
    chk("R6 R7 survive clr_flags", status_o, 8'h0A);
    peer_rd_i = 1; nstep(); quiet();
    chk("R6 nak survives peer_rd", status_o, 8'h08);
    reconf_evt_i = 1; peer_evt_i = 1; nstep(); quiet();
    por_clr_i = 1; nstep(); quiet();
    chk("R7 peer survives por_clr", status_o, 8'h06);

    // R8 set beats clear in the same cycle
    reconf_evt_i = 1; clr_flags_i = 1; nak_evt_i = 1; por_clr_i = 1;
    peer_evt_i = 1; peer_rd_i = 1; nstep(); quiet();
    chk("R8 set wins", status_o, 8'h0E);

    finish_run();
  end
endmodule